// File: doc/BRIEF.md
# External Bus Cycle Controller

This block turns internal read and write requests, each either a byte or a 16-bit word, into cycles on a multiplexed 16-bit address/data bus. Every cycle starts with an address state, in which both byte lanes carry the address. One or more data states follow, and an end state closes the cycle. An address strobe marks the address. Read, write and byte-select strobes mark the data transfer. A READY input can stretch the data phase, and a bus-width input lets the external system pick an 8-bit or a 16-bit transfer for each cycle.

A configuration byte is sampled once, on the first clock after reset is released. It fixes four policies until the next reset: whether 16-bit transfers are allowed at all, whether writes use one strobe plus a high-byte enable or a pair of per-lane write strobes, whether the address strobe is a short high latch pulse or an active-low valid level, and how many wait states READY may insert. On an 8-bit transfer, a word request is split into two byte transfers on the low lane. The high lane keeps the upper address byte for the whole cycle.

Top module: `ebc_bus_ctrl`

## Requirements
- R1: While reset is active, and until the configuration is captured, `req_ready` is 0, `rsp_done` is 0, `ad_oe` is 00 and `rd_n`, `stb_a_n`, `stb_b_n` are 1. `cfg_in` is captured on the third rising clock edge after `rst_n` rises, which is when `req_ready` first goes to 1. Later changes on `cfg_in` have no effect until the next reset.
- R2: A cycle is 16-bit only when configuration bit 1 and `bw_in` are both 1. `bw_in` is sampled at the end of the address state and holds for the rest of that cycle. In every other case the cycle is 8-bit.
- R3: In the address state `ad_oe` is 11 and `ad_out` carries the request address. If configuration bit 3 is 1, `astb` is 1 only in the address state. If bit 3 is 0, `astb` is 0 from the first data state through the end state and 1 at all other times.
- R4: In an 8-bit cycle, `ad_out[15:8]` holds address bits 15:8 with `ad_oe[1]` set for the whole cycle. Data uses `ad_out[7:0]` / `ad_in[7:0]`, and `ad_oe[0]` is 1 after the address state only for writes.
- R5: With configuration bit 2 = 1, `stb_a_n` is one write strobe, low in the data states of writes. `stb_b_n` is a high-byte enable, low in every state of a cycle that is a word or targets an odd address.
- R6: With configuration bit 2 = 0 in a 16-bit cycle, `stb_a_n` (low lane) is low in the data states of a word write or an even-address byte write. `stb_b_n` (high lane) is low in the data states of a word write or an odd-address byte write. Every 8-bit write uses `stb_a_n`, and `stb_b_n` then stays 1.
- R7: Configuration bits 5:4 set the wait-state limit: 00 allows 1, 01 allows 2, 10 allows 3, and 11 removes the limit.
- R8: In each data state `ready_in` is sampled at the clock edge. If it is 0 and fewer wait states than the limit have been inserted, one more data state follows. A cycle with w wait states lasts 3+w states from the address state through the end state, and `rsp_done` is 1 for exactly its end state.
- R9: In an 8-bit cycle a word read adds one data state, in which the high byte is taken from `ad_in[7:0]` with `rd_n` held low. A word write adds two states: a gap with the strobe released, then a data state with `wdata[15:8]` on the low lane. The low byte moves first in both cases.
- R10: Read data is returned on `rsp_rdata` during the end state. A 16-bit word returns `ad_in`. A 16-bit byte returns `ad_in[15:8]` for an odd address and `ad_in[7:0]` for an even address. An 8-bit byte returns `ad_in[7:0]`. Byte results are zero-extended.
- R11: In a 16-bit write cycle, both lanes are driven after the address state. A word carries `req_wdata`, and a byte carries `req_wdata[7:0]` copied onto both lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_in | input | 8 | Configuration byte, sampled once after reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word (even address), 0 = byte |
| req_addr | input | 16 | Request address |
| req_wdata | input | 16 | Write data; a byte uses bits 7:0 |
| req_ready | output | 1 | Request accepted on this edge when valid |
| rsp_done | output | 1 | End state of the current cycle |
| rsp_rdata | output | 16 | Read result |
| bw_in | input | 1 | External request for a 16-bit transfer |
| ready_in | input | 1 | External ready; 0 asks for a wait state |
| ad_in | input | 16 | Bus value seen on the address/data lanes |
| ad_out | output | 16 | Value driven onto the address/data lanes |
| ad_oe | output | 2 | Lane drive enables: bit 1 high lane, bit 0 low lane |
| astb | output | 1 | Address latch pulse or active-low address-valid level |
| rd_n | output | 1 | Read strobe, active low |
| stb_a_n | output | 1 | Write strobe, or low-lane write strobe |
| stb_b_n | output | 1 | High-byte enable, or high-lane write strobe |

## Verification
Two mechanisms can end a data phase in the same state: READY rising, and the wait-state limiter running out. The bench sweeps the READY-low length k from 0 to 4 against every limit setting, so k equal to the limit makes both happen on the same edge. It judges the result by the state in which `rsp_done` appears and by the read data taken in that final data state. A second overlap occurs when an 8-bit word transfer's extra byte state follows a stretched first byte. In that case the bench checks the latency and the high byte's position together.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

  localparam int WLIM_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_DATA  = 3'd2,
    ST_GAP   = 3'd3,
    ST_DATA2 = 3'd4,
    ST_END   = 3'd5
  } ebc_state_e;

  typedef struct packed {
    logic [WLIM_W-1:0] wlim;      // wait limit code
    logic              pulse_as;  // 1: latch pulse, 0: valid level
    logic              single_wr; // 1: one write strobe + high enable
    logic              wide_en;   // 16-bit transfers permitted
  } ebc_cfg_t;

endpackage

// File: rtl/ebc_rst_sync.sv
module ebc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ebc_cfg_capture.sv
module ebc_cfg_capture
  import ebc_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_raw,
  output ebc_cfg_t         cfg,
  output logic             cfg_ok
);
  ebc_cfg_t cfg_q, cfg_d;
  logic     ok_q;
  logic     cap_en;
  logic     unused_cfg_bits;

  assign cap_en = !ok_q;

  always_comb begin
    cfg_d.wide_en   = cfg_raw[1];
    cfg_d.single_wr = cfg_raw[2];
    cfg_d.pulse_as  = cfg_raw[3];
    cfg_d.wlim      = cfg_raw[5:4];
  end

  assign unused_cfg_bits = ^{cfg_raw[0], cfg_raw[CFG_W-1:6]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ok_q  <= 1'b0;
    end else if (cap_en) begin
      cfg_q <= cfg_d;
      ok_q  <= 1'b1;
    end
  end

  assign cfg    = cfg_q;
  assign cfg_ok = ok_q;

  // R1
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q |=> (ok_q && $stable(cfg_q)));
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ebc_cfg_t          cfg,
  input  logic              cfg_ok,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [DATA_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              bw_in,
  input  logic              ready_in,
  input  logic [DATA_W-1:0] ad_in,
  output ebc_state_e        st,
  output logic              bus16,
  output logic              second,
  output logic              wr,
  output logic              word,
  output logic [DATA_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              req_ready,
  output logic              rsp_done
);
  localparam int LANE_W = DATA_W / 2;

  ebc_state_e        st_q, st_d;
  logic [WLIM_W-1:0] wcnt_q, wcnt_d;
  logic [WLIM_W-1:0] lim;
  logic              lim_off;
  logic              stretch;
  logic              split;
  logic              req_ld, bw_ld, rlo_ld, rhi_ld, sec_set;
  logic              bus16_q, second_q, wr_q, word_q;
  logic [DATA_W-1:0] addr_q, wdata_q, rdata_q, rlo;

  assign lim     = cfg.wlim + 1'b1;
  assign lim_off = (cfg.wlim == '1);
  assign stretch = (st_q == ST_DATA) && !ready_in && (lim_off || (wcnt_q < lim));
  assign split   = word_q && !bus16_q;

  assign req_ld  = (st_q == ST_IDLE) && req_valid && cfg_ok;
  assign bw_ld   = (st_q == ST_ADDR);
  assign rlo_ld  = (st_q == ST_DATA) && !stretch && !wr_q;
  assign rhi_ld  = (st_q == ST_DATA2) && !wr_q;
  assign sec_set = (st_d == ST_DATA2) && (st_q != ST_DATA2);

  always_comb begin
    st_d   = st_q;
    wcnt_d = wcnt_q;
    case (st_q)
      ST_IDLE:  if (req_ld) st_d = ST_ADDR;
      ST_ADDR: begin
        st_d   = ST_DATA;
        wcnt_d = '0;
      end
      ST_DATA: begin
        if (stretch) begin
          if (wcnt_q != '1) wcnt_d = wcnt_q + 1'b1;
        end else if (split) begin
          st_d = wr_q ? ST_GAP : ST_DATA2;
        end else begin
          st_d = ST_END;
        end
      end
      ST_GAP:   st_d = ST_DATA2;
      ST_DATA2: st_d = ST_END;
      ST_END:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (bus16_q) begin
      if (word_q)        rlo = ad_in;
      else if (addr_q[0]) rlo = {{LANE_W{1'b0}}, ad_in[DATA_W-1:LANE_W]};
      else               rlo = {{LANE_W{1'b0}}, ad_in[LANE_W-1:0]};
    end else begin
      rlo = {{LANE_W{1'b0}}, ad_in[LANE_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      word_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (req_ld) begin
      wr_q    <= req_write;
      word_q  <= req_word;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus16_q <= 1'b0;
    else if (bw_ld) bus16_q <= cfg.wide_en && bw_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       second_q <= 1'b0;
    else if (req_ld)  second_q <= 1'b0;
    else if (sec_set) second_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rlo_ld) rdata_q <= rlo;
    else if (rhi_ld) rdata_q[DATA_W-1:LANE_W] <= ad_in[LANE_W-1:0];
  end

  assign st        = st_q;
  assign bus16     = bus16_q;
  assign second    = second_q;
  assign wr        = wr_q;
  assign word      = word_q;
  assign addr      = addr_q;
  assign wdata     = wdata_q;
  assign rdata     = rdata_q;
  assign req_ready = (st_q == ST_IDLE) && cfg_ok;
  assign rsp_done  = (st_q == ST_END);

  // R8
  ready_ends_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && ready_in) |=> (st_q != ST_DATA));

  // R7
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && !lim_off) |-> (wcnt_q <= lim));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R2
  width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_ADDR) |=> $stable(bus16_q));
endmodule

// File: rtl/ebc_pins.sv
module ebc_pins
  import ebc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ebc_cfg_t          cfg,
  input  ebc_state_e        st,
  input  logic              bus16,
  input  logic              second,
  input  logic              wr,
  input  logic              word,
  input  logic [DATA_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ad_out,
  output logic [1:0]        ad_oe,
  output logic              astb,
  output logic              rd_n,
  output logic              stb_a_n,
  output logic              stb_b_n
);
  localparam int LANE_W = DATA_W / 2;

  logic active, addr_ph, data_ph, post;
  logic lo_sel, hi_sel;
  logic [LANE_W-1:0] lo_byte;

  assign active  = (st != ST_IDLE);
  assign addr_ph = (st == ST_ADDR);
  assign data_ph = (st == ST_DATA) || (st == ST_DATA2);
  assign post    = active && !addr_ph;
  assign lo_sel  = word || !addr[0];
  assign hi_sel  = word || addr[0];
  assign lo_byte = second ? wdata[DATA_W-1:LANE_W] : wdata[LANE_W-1:0];

  always_comb begin
    astb = cfg.pulse_as ? addr_ph : !post;
    rd_n = !(!wr && data_ph);
    if (cfg.single_wr) begin
      stb_a_n = !(wr && data_ph);
      stb_b_n = !(active && hi_sel);
    end else begin
      stb_a_n = !(wr && data_ph && (!bus16 || lo_sel));
      stb_b_n = !(wr && data_ph && bus16 && hi_sel);
    end
  end

  always_comb begin
    if (addr_ph) begin
      ad_oe  = 2'b11;
      ad_out = addr;
    end else if (post) begin
      ad_oe = wr ? 2'b11 : (bus16 ? 2'b00 : 2'b10);
      if (bus16)
        ad_out = word ? wdata : {wdata[LANE_W-1:0], wdata[LANE_W-1:0]};
      else
        ad_out = {addr[DATA_W-1:LANE_W], lo_byte};
    end else begin
      ad_oe  = 2'b00;
      ad_out = '0;
    end
  end

  // R5
  no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !stb_a_n));

  // R6
  narrow_high_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.single_wr && post && !bus16) |-> stb_b_n);

  // R4
  narrow_high_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (post && !bus16) |-> (ad_oe[1] && ad_out[DATA_W-1:LANE_W] == addr[DATA_W-1:LANE_W]));
endmodule

// File: rtl/ebc_bus_ctrl.sv
module ebc_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CFG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_in,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [DATA_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              bw_in,
  input  logic              ready_in,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic [1:0]        ad_oe,
  output logic              astb,
  output logic              rd_n,
  output logic              stb_a_n,
  output logic              stb_b_n
);
  logic              rst_sync_n;
  ebc_cfg_t          cfg;
  logic              cfg_ok;
  ebc_state_e        st;
  logic              bus16, second, wr, word;
  logic [DATA_W-1:0] addr, wdata;

  ebc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ebc_cfg_capture #(.CFG_W(CFG_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cfg_raw (cfg_in),
    .cfg     (cfg),
    .cfg_ok  (cfg_ok)
  );

  ebc_seq #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg       (cfg),
    .cfg_ok    (cfg_ok),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_word  (req_word),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .bw_in     (bw_in),
    .ready_in  (ready_in),
    .ad_in     (ad_in),
    .st        (st),
    .bus16     (bus16),
    .second    (second),
    .wr        (wr),
    .word      (word),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rsp_rdata),
    .req_ready (req_ready),
    .rsp_done  (rsp_done)
  );

  ebc_pins #(.DATA_W(DATA_W)) u_pins (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cfg     (cfg),
    .st      (st),
    .bus16   (bus16),
    .second  (second),
    .wr      (wr),
    .word    (word),
    .addr    (addr),
    .wdata   (wdata),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .astb    (astb),
    .rd_n    (rd_n),
    .stb_a_n (stb_a_n),
    .stb_b_n (stb_b_n)
  );
endmodule

// File: tb/ebc_bus_ctrl_tb.sv
module ebc_bus_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cfg_in;
  logic        req_valid, req_write, req_word;
  logic [15:0] req_addr, req_wdata;
  logic        req_ready, rsp_done;
  logic [15:0] rsp_rdata;
  logic        bw_in, ready_in;
  logic [15:0] ad_in, ad_out;
  logic [1:0]  ad_oe;
  logic        astb, rd_n, stb_a_n, stb_b_n;

  int checks = 0;
  int fails  = 0;
  int serial = 0;

  always #4 clk = ~clk;

  ebc_bus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in),
    .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bw_in(bw_in), .ready_in(ready_in), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .astb(astb), .rd_n(rd_n),
    .stb_a_n(stb_a_n), .stb_b_n(stb_b_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] cfg);
    logic [3:0] seen;
    @(negedge clk);
    rst_n = 1'b0;
    cfg_in = cfg;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0 && rsp_done == 1'b0 && ad_oe == 2'b00 && rd_n && stb_a_n && stb_b_n,
        "R1 reset state", {req_ready, rsp_done, ad_oe, rd_n, stb_a_n, stb_b_n}, 32'h7);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      seen[i] = req_ready;
    end
    seen[3] = 1'b0;
    chk(seen == 4'b0100, "R1 capture edge", seen, 4'b0100);
    cfg_in = ~cfg;
  endtask

  task automatic run_txn(input logic [7:0] cfg, input bit bw, input bit wr, input int ty, input int k);
    bit          word, a0, b16, lim_off, split;
    int          lim, w, tot, done_i, done_n, ph;
    logic [15:0] addr, wdata, e_ad, mask, e_rd;
    logic [7:0]  plo, phi, q;
    bit          e_astb, e_rdn, e_a, e_b, act, ap, dp, post;
    logic [1:0]  e_oe;
    bit          err_as, err_ad, err_st;
    logic [31:0] as_a, as_e, ad_a, ad_e, st_a, st_e;
    string       tg;
    serial++;
    word    = (ty == 2);
    a0      = (ty == 1);
    addr    = {serial[7:0] ^ 8'h5A, serial[6:0] ^ 7'h21, a0};
    wdata   = {serial[7:0] ^ 8'h96, serial[7:0] ^ 8'h3B};
    plo     = serial[7:0] ^ 8'h3C;
    phi     = serial[7:0] ^ 8'hC3;
    q       = serial[7:0] + 8'h5A;
    b16     = cfg[1] && bw;
    lim_off = (cfg[5:4] == 2'b11);
    lim     = int'(cfg[5:4]) + 1;
    w       = lim_off ? k : ((k < lim) ? k : lim);
    split   = word && !b16;
    tot     = 3 + w + (split ? (wr ? 2 : 1) : 0);
    done_i  = 0;
    done_n  = 0;
    err_as = 0; err_ad = 0; err_st = 0;
    as_a = 0; as_e = 0; ad_a = 0; ad_e = 0; st_a = 0; st_e = 0;

    @(negedge clk);
    chk(req_ready == 1'b1, "R1 idle accepts", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_word = word;
    req_addr = addr; req_wdata = wdata;
    bw_in = bw; ready_in = 1'b0; ad_in = {phi, plo};

    for (int i = 1; i <= tot + 2; i++) begin
      @(negedge clk);
      if (i == 1) req_valid = 1'b0;
      ready_in = (i >= k + 2);
      ad_in    = (i >= 3 + w) ? {phi, q} : {phi, plo};
      // phase codes: 0 idle, 1 addr, 2 data, 3 gap, 4 second data, 5 end
      if (i == 1) ph = 1;
      else if (i <= 2 + w) ph = 2;
      else begin
        int j;
        j = i - (3 + w);
        if (!split)  ph = (j == 0) ? 5 : 0;
        else if (wr) ph = (j == 0) ? 3 : (j == 1) ? 4 : (j == 2) ? 5 : 0;
        else         ph = (j == 0) ? 4 : (j == 1) ? 5 : 0;
      end
      act  = (ph != 0);
      ap   = (ph == 1);
      dp   = (ph == 2) || (ph == 4);
      post = act && !ap;
      e_astb = cfg[3] ? ap : !post;
      e_rdn  = !(!wr && dp);
      if (cfg[2]) begin
        e_a = !(wr && dp);
        e_b = !(act && (word || a0));
      end else begin
        e_a = !(wr && dp && (!b16 || word || !a0));
        e_b = !(wr && dp && b16 && (word || a0));
      end
      e_oe = ap ? 2'b11 : (post ? (wr ? 2'b11 : (b16 ? 2'b00 : 2'b10)) : 2'b00);
      if (ap) e_ad = addr;
      else if (b16) e_ad = word ? wdata : {wdata[7:0], wdata[7:0]};
      else e_ad = {addr[15:8], ((ph == 4) || (ph == 5 && split)) ? wdata[15:8] : wdata[7:0]};
      mask = {{8{e_oe[1]}}, {8{e_oe[0]}}};
      if (astb !== e_astb && !err_as) begin
        err_as = 1; as_a = {i[15:0], 15'd0, astb}; as_e = {i[15:0], 15'd0, e_astb};
      end
      if ((ad_oe !== e_oe || ((ad_out & mask) !== (e_ad & mask))) && !err_ad) begin
        err_ad = 1; ad_a = {14'd0, ad_oe, ad_out & mask}; ad_e = {14'd0, e_oe, e_ad & mask};
      end
      if ({rd_n, stb_a_n, stb_b_n} !== {e_rdn, e_a, e_b} && !err_st) begin
        err_st = 1; st_a = {i[15:0], 13'd0, rd_n, stb_a_n, stb_b_n};
        st_e = {i[15:0], 13'd0, e_rdn, e_a, e_b};
      end
      if (rsp_done) begin
        done_n++;
        if (done_i == 0) done_i = i;
        if (!wr) begin
          if (b16) e_rd = word ? {phi, plo} : {8'h00, a0 ? phi : plo};
          else     e_rd = word ? {q, plo} : {8'h00, plo};
          tg = split ? "R9 read data" : "R10 read data";
          chk(rsp_rdata == e_rd, tg, rsp_rdata, e_rd);
        end
      end
    end
    chk(!err_as, "R3 address strobe", as_a, as_e);
    tg = b16 ? "R11 lanes" : (cfg[1] ? "R2 lanes" : "R4 lanes");
    chk(!err_ad, tg, ad_a, ad_e);
    tg = cfg[2] ? "R5 strobes" : "R6 strobes";
    chk(!err_st, tg, st_a, st_e);
    tg = (!lim_off && k > lim) ? "R7 latency" : (split ? "R9 latency" : "R8 latency");
    chk(done_i == tot && done_n == 1, tg, {done_n[15:0], done_i[15:0]}, {16'd1, tot[15:0]});
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_in = 8'h00; req_valid = 1'b0; req_write = 1'b0;
    req_word = 1'b0; req_addr = '0; req_wdata = '0; bw_in = 1'b0;
    ready_in = 1'b1; ad_in = '0;
    for (int c = 0; c < 32; c++) begin
      logic [7:0] cfg;
      cfg = {c[1], c[0], c[4], c[3], c[2], c[1], c[0], ~c[0]};
      do_reset(cfg);
      for (int bw = 0; bw < 2; bw++)
        for (int wr = 0; wr < 2; wr++)
          for (int ty = 0; ty < 3; ty++)
            for (int k = 0; k < 5; k++)
              run_txn(cfg, bw[0], wr[0], ty, k);
    end
    summary();
    $finish;
  end
endmodule